// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a sequential word store with two fully independent ports, each running on its own clock. The write side places one byte per enabled write-clock edge at the address held in its own counter. The read side presents one byte per enabled read-clock edge from the address held in a second counter. There are no fill-level flags. The only way to position either counter is its own active-low synchronous reset. A line delay is therefore built by resetting both counters at the start of a line, or by offsetting the resets or the read enables by the wanted number of cycles.

A byte captured on a write edge is not yet in storage after that edge. It is committed on the following write-clock edge, whether that edge is enabled or not. A read of that location before the commit returns the previous contents. When the read port is disabled, the output is marked undriven by a registered output-enable flag, and the data lines hold their last value.

Top module: `dual_clock_line_store`

## Requirements
- R1: The store holds DEPTH words of WIDTH bits (defaults 5120 and 8). Every address written in one pass returns its own byte when the line is read back in order.
- R2: On a write-clock rising edge with `wr_en_n` low, `wr_data` is captured for the current write address, and the write counter advances by one.
- R3: On a write-clock edge with `wr_en_n` high, nothing is stored and the write counter keeps its value.
- R4: On a write-clock edge with `wr_rst_n` low, the write address used is 0. The counter then becomes 1 if `wr_en_n` is low, or 0 if `wr_en_n` is high.
- R5: On a read-clock rising edge with `rd_en_n` low, `rd_data` takes the word at the current read address, `rd_oe` becomes 1, and the read counter advances by one.
- R6: On a read-clock edge with `rd_en_n` high, `rd_oe` becomes 0, `rd_data` holds its value, and the read counter does not move.
- R7: On a read-clock edge with `rd_rst_n` low, the read address used is 0 and the read counter becomes 0. Word 0 is therefore presented on the reset edge and again on the next enabled edge, before reads move to word 1.
- R8: A byte captured on write edge n is committed to storage on write edge n+1, even when edge n+1 is disabled. A read of that address before edge n+1 returns the old contents.
- R9: Both counters step from DEPTH-1 to 0 with no indication, and neither counter ever holds a value of DEPTH or more.
- R10: The two ports run on unrelated clocks. A reader that starts a line after the writer, and reads no faster than the writer, gets every new byte of that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Synchronous write-address reset, active low |
| wr_data | input | WIDTH | Byte to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Synchronous read-address reset, active low |
| rd_data | output | WIDTH | Registered read word |
| rd_oe | output | 1 | Registered output-enable (0 models high impedance) |

## Verification
The properties are only meaningful once each port has seen its own reset, because the counters have no power-on state. Each domain's checks therefore stay disarmed until that port's reset has been sampled low once. The checks also assume that every control input changes only away from its own clock edge. The stimulus meets both conditions: it asserts both resets before any other traffic, and it drives every input on the falling edge of the clock that samples it. The write clock is gated only while it is low, so the gated clock never produces a runt edge.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
package lm_pkg;
    localparam int unsigned LM_DEF_DEPTH = 5120;
    localparam int unsigned LM_DEF_WIDTH = 8;

    // step an address, folding the last slot back to zero
    function automatic int unsigned lm_step(input int unsigned cur, input int unsigned last);
        return (cur == last) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/lm_array.sv
`timescale 1ns/1ps
module lm_array #(
    parameter int unsigned DEPTH = lm_pkg::LM_DEF_DEPTH,
    parameter int unsigned WIDTH = lm_pkg::LM_DEF_WIDTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells_q [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = re ? cells_q[raddr] : rdata_q;
    end

    always_ff @(posedge rclk) begin
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/lm_wr_port.sv
`timescale 1ns/1ps
module lm_wr_port #(
    parameter int unsigned DEPTH = lm_pkg::LM_DEF_DEPTH,
    parameter int unsigned WIDTH = lm_pkg::LM_DEF_WIDTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en_n,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_din,
    output logic [AW-1:0]    cnt
);
    typedef struct packed {
        logic [AW-1:0]    cnt;
        logic             stg_vld;
        logic [AW-1:0]    stg_addr;
        logic [WIDTH-1:0] stg_data;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [AW-1:0] slot;

    always_comb begin
        slot           = rst_n ? st_q.cnt : '0;
        st_d           = st_q;
        // capture stage: committed on the next edge of this clock
        st_d.stg_vld   = !en_n;
        st_d.stg_addr  = slot;
        st_d.stg_data  = din;
        st_d.cnt       = en_n ? slot
                              : AW'(lm_pkg::lm_step(32'(slot), 32'(DEPTH - 1)));
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_we   = st_q.stg_vld;
    assign mem_addr = st_q.stg_addr;
    assign mem_din  = st_q.stg_data;
    assign cnt      = st_q.cnt;
endmodule

// File: rtl/lm_rd_port.sv
`timescale 1ns/1ps
module lm_rd_port #(
    parameter int unsigned DEPTH = lm_pkg::LM_DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en_n,
    input  logic          rst_n,
    output logic          fetch,
    output logic [AW-1:0] fetch_addr,
    output logic          oe,
    output logic [AW-1:0] cnt
);
    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          oe;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [AW-1:0] slot;

    always_comb begin
        slot      = rst_n ? st_q.cnt : '0;
        st_d      = st_q;
        st_d.oe   = !en_n;
        if (!rst_n)     st_d.cnt = '0;
        else if (!en_n) st_d.cnt = AW'(lm_pkg::lm_step(32'(slot), 32'(DEPTH - 1)));
        else            st_d.cnt = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch      = !en_n;
    assign fetch_addr = slot;
    assign oe         = st_q.oe;
    assign cnt        = st_q.cnt;
endmodule

// File: rtl/dual_clock_line_store.sv
`timescale 1ns/1ps
module dual_clock_line_store #(
    parameter int unsigned DEPTH = lm_pkg::LM_DEF_DEPTH,
    parameter int unsigned WIDTH = lm_pkg::LM_DEF_WIDTH
) (
    input  logic             wr_clk,
    input  logic             wr_en_n,
    input  logic             wr_rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_en_n,
    input  logic             rd_rst_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic             commit_we;
    logic [AW-1:0]    commit_addr;
    logic [WIDTH-1:0] commit_data;
    logic [AW-1:0]    wr_cnt;
    logic             fetch;
    logic [AW-1:0]    fetch_addr;
    logic [AW-1:0]    rd_cnt;

    lm_wr_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
        .clk(wr_clk), .en_n(wr_en_n), .rst_n(wr_rst_n), .din(wr_data),
        .mem_we(commit_we), .mem_addr(commit_addr), .mem_din(commit_data),
        .cnt(wr_cnt)
    );

    lm_rd_port #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .en_n(rd_en_n), .rst_n(rd_rst_n),
        .fetch(fetch), .fetch_addr(fetch_addr), .oe(rd_oe), .cnt(rd_cnt)
    );

    lm_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .wclk(wr_clk), .we(commit_we), .waddr(commit_addr), .wdata(commit_data),
        .rclk(rd_clk), .re(fetch), .raddr(fetch_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/lm_checker.sv
`timescale 1ns/1ps
module lm_checker #(
    parameter int unsigned DEPTH = lm_pkg::LM_DEF_DEPTH,
    parameter int unsigned WIDTH = lm_pkg::LM_DEF_WIDTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input logic             wr_clk,
    input logic             wr_en_n,
    input logic             wr_rst_n,
    input logic [AW-1:0]    wr_cnt,
    input logic             rd_clk,
    input logic             rd_en_n,
    input logic             rd_rst_n,
    input logic [AW-1:0]    rd_cnt,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_oe
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic w_arm_q = 1'b0;
    logic r_arm_q = 1'b0;

    always_ff @(posedge wr_clk) if (!wr_rst_n) w_arm_q <= 1'b1;
    always_ff @(posedge rd_clk) if (!rd_rst_n) r_arm_q <= 1'b1;

    AST_WR_ADVANCE: assert property (@(posedge wr_clk) disable iff (!w_arm_q)
        (!wr_en_n && wr_rst_n && wr_cnt != LAST) |=> wr_cnt == $past(wr_cnt) + 1'b1); // R2
    AST_WR_HOLD: assert property (@(posedge wr_clk) disable iff (!w_arm_q)
        (wr_en_n && wr_rst_n) |=> $stable(wr_cnt)); // R3
    AST_WR_RESET: assert property (@(posedge wr_clk) disable iff (!w_arm_q)
        (!wr_rst_n) |=> wr_cnt == ($past(wr_en_n) ? AW'(0) : AW'(1))); // R4
    AST_WR_WRAP: assert property (@(posedge wr_clk) disable iff (!w_arm_q)
        (!wr_en_n && wr_rst_n && wr_cnt == LAST) |=> wr_cnt == '0); // R9
    AST_WR_RANGE: assert property (@(posedge wr_clk) disable iff (!w_arm_q)
        32'(wr_cnt) < DEPTH); // R9
    AST_RD_ENABLE: assert property (@(posedge rd_clk) disable iff (!r_arm_q)
        (!rd_en_n) |=> rd_oe); // R5
    AST_RD_DISABLE: assert property (@(posedge rd_clk) disable iff (!r_arm_q)
        (rd_en_n && rd_rst_n) |=> (!rd_oe && $stable(rd_data) && $stable(rd_cnt))); // R6
    AST_RD_RESET: assert property (@(posedge rd_clk) disable iff (!r_arm_q)
        (!rd_rst_n) |=> rd_cnt == '0); // R7
    AST_RD_WRAP: assert property (@(posedge rd_clk) disable iff (!r_arm_q)
        (!rd_en_n && rd_rst_n && rd_cnt == LAST) |=> rd_cnt == '0); // R9
endmodule

bind dual_clock_line_store lm_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n), .wr_cnt(wr_cnt),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_rst_n(rd_rst_n), .rd_cnt(rd_cnt),
    .rd_data(rd_data), .rd_oe(rd_oe)
);

// File: tb/tb_dual_clock_line_store.sv
`timescale 1ns/1ps
module tb_dual_clock_line_store;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;

    logic wclk_gen = 1'b0;
    logic wclk_run = 1'b1;
    logic wr_clk;
    logic rd_clk = 1'b0;
    logic wr_en_n = 1'b1, wr_rst_n = 1'b1;
    logic rd_en_n = 1'b1, rd_rst_n = 1'b1;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic rd_oe;

    always #2.5 wclk_gen = ~wclk_gen;   // 200 MHz write clock
    always #3.5 rd_clk = ~rd_clk;       // unrelated read clock
    assign wr_clk = wclk_gen & wclk_run;

    dual_clock_line_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_rst_n(rd_rst_n),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    int n_chk = 0, n_err = 0;
    logic [WIDTH-1:0] exp_mem [DEPTH];
    int wp = 0, rp = 0;
    logic [WIDTH-1:0] exp_q = '0;
    bit have_q = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr_op(bit wr, bit rs, logic [WIDTH-1:0] d);
        int a;
        @(negedge wclk_gen);
        wr_en_n = !wr; wr_rst_n = !rs; wr_data = d;
        @(posedge wclk_gen);
        #0.5;
        wr_en_n = 1'b1; wr_rst_n = 1'b1;
        a = rs ? 0 : wp;
        if (wr) begin
            exp_mem[a] = d;
            wp = (a + 1) % DEPTH;
        end else begin
            wp = a;
        end
    endtask

    task automatic rd_op(bit rd, bit rs, string tag);
        int a;
        @(negedge rd_clk);
        rd_en_n = !rd; rd_rst_n = !rs;
        @(posedge rd_clk);
        #1;
        a = rs ? 0 : rp;
        if (rd) begin
            exp_q = exp_mem[a];
            have_q = 1;
        end
        rp = rs ? 0 : (rd ? (a + 1) % DEPTH : rp);
        chk(rd_oe == rd, {tag, " oe"}, int'(rd_oe), int'(rd));
        if (have_q) chk(rd_data == exp_q, tag, int'(rd_data), int'(exp_q));
        rd_en_n = 1'b1; rd_rst_n = 1'b1;
    endtask

    task automatic write_line(int base, int step);
        wr_op(1, 1, WIDTH'(base));
        for (int i = 1; i < DEPTH; i++) wr_op(1, 0, WIDTH'(base + i * step));
    endtask

    task automatic read_line(string tag);
        rd_op(1, 1, {tag, " R7 reset word"});
        for (int i = 0; i < DEPTH; i++) rd_op(1, 0, tag);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog got=%0h exp=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] old0;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        // reset state: both ports reset with enables off -> output disabled
        wr_op(0, 1, '0);
        rd_op(0, 1, "R6 reset state");
        rd_op(0, 0, "R6 idle");

        // R1 R2 R5 R7: full line, several patterns
        write_line(8'h03, 7);
        read_line("R1 line A");
        write_line(8'hF0, 8'h13);
        read_line("R1 line B");
        // R9 read wrap: one more read after a full line returns word 0
        rd_op(1, 0, "R9 read wrap");

        // R9 write wrap: keep writing past the end without reset
        for (int i = 0; i < DEPTH + 5; i++) wr_op(1, 0, WIDTH'(8'h40 + i * 5));
        read_line("R9 write wrap");

        // R3: disabled write cycles store nothing and hold the counter
        wr_op(1, 1, 8'h11);
        for (int i = 1; i < DEPTH; i++) begin
            wr_op(0, 0, 8'hEE);
            wr_op(1, 0, WIDTH'(8'h11 + i * 3));
        end
        read_line("R3 gapped write");

        // R6: disabled read cycles float output, hold data and address
        rd_op(1, 1, "R6 setup");
        for (int i = 0; i < 6; i++) begin
            rd_op(0, 0, "R6 disabled");
            rd_op(1, 0, "R5 resumed");
        end

        // R4: write reset mid-line, with and without enable
        for (int i = 0; i < 5; i++) wr_op(1, 0, WIDTH'(8'hA0 + i));
        wr_op(1, 1, 8'h5A);
        wr_op(1, 0, 8'h5B);
        wr_op(0, 1, 8'hCC);
        wr_op(1, 0, 8'h77);
        read_line("R4 write reset");

        // R7: read reset mid-line, word 0 repeats through reset cycles
        rd_op(1, 1, "R7 a");
        for (int i = 0; i < 4; i++) rd_op(1, 0, "R7 mid");
        rd_op(1, 1, "R7 reset 1");
        rd_op(1, 1, "R7 reset 2");
        rd_op(1, 0, "R7 repeat");
        rd_op(1, 0, "R7 next");

        // R8: captured byte invisible until the next write edge
        old0 = exp_mem[0];
        wr_op(1, 1, ~old0);
        @(negedge wclk_gen); wclk_run = 1'b0;
        exp_mem[0] = old0;
        rd_op(1, 1, "R8 before commit");
        rd_op(1, 1, "R8 still pending");
        @(negedge wclk_gen); wclk_run = 1'b1;
        @(posedge wclk_gen); #0.5;
        exp_mem[0] = ~old0;
        rd_op(1, 1, "R8 after commit");

        // R10: concurrent writer and slower reader on unrelated clocks
        fork
            write_line(8'h80, 3);
            begin
                #40;
                read_line("R10 concurrent");
            end
        join

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule